// File: doc/BRIEF.md
# Blanking-Line Slot Sequencer

This block drives the horizontal slot counter of a tile-based video processor while the current line is outside active rendering, which covers the vertical blanking lines and the top and bottom border lines. One clock equals one access slot. The counter runs through a sequence with a gap: it leaves out a range of values at a point that depends on the display mode. Fixed slots in that sequence raise single-cycle strobes to the sprite engine and the interrupt logic. The block also keeps the vertical line counter.

Three display modes are supported. They are a wide mode of 320 pixels, a narrow mode of 256 pixels and a legacy compatibility mode. On border lines the block emits a pixel write per slot inside the horizontal window. Each write covers two identical pixels, and its palette address is formed from the background-colour index. A slot-duration output gives the number of master-clock cycles that each slot lasts. A downstream timing unit can use it to convert slots to time.

The mode inputs are latched at the line-change slot, so a new mode takes effect on the next line. The sequence-end strobe tells the surrounding controller that the next line is an active one.

Top module: `vblank_slot_seq`

## Requirements
- R1: A synchronous active-high reset sets the slot counter to 0, loads the vertical counter from the inactive-start input and latches the mode inputs. In the first cycle after reset every strobe and pix_we is low.
- R2: The slot counter jumps from 182 to 229 in wide mode. In narrow and legacy modes it jumps from 147 to 233. Every other slot advances by one, wrapping from 255 to 0.
- R3: buf_clear is high for exactly the slot 161 in wide mode, 128 in narrow mode and 136 in legacy mode.
- R4: idx_reset is high for exactly the slot 165 in wide mode, where idx_load is 0x80. It is high for slot 132 in narrow mode, where idx_load is 0x80. It is high for slot 253 in legacy mode, where idx_load is 0x00.
- R5: On a border line, pix_we is high for slots 9 to 168 in wide mode and for slots 9 to 136 in the other modes. During those slots pix_idx = 2*(slot-9), which is the first of the two pixels written.
- R6: A line is a border line when vline < inactive_start + border_bottom or vline > 0x200 - border_top, compared without truncation. On any other line pix_we stays low.
- R7: In narrow and wide modes pix_color is {0, bg_index[5:0]}. In legacy mode it is {3'b101, bg_index[3:0]}.
- R8: vint_set is high for one slot per frame. That slot is 2 in wide mode, 1 in narrow mode and 3 in legacy mode. In narrow and wide modes it occurs on line inactive_start. In legacy mode it occurs on line inactive_start+1, modulo 512.
- R9: line_adv is high during the line-change slot, which is 166 in wide mode, 133 in narrow mode and 134 in legacy mode. On the following slot vline has advanced by one, modulo 512. At all other times vline holds.
- R10: seq_done is high together with line_adv when the advanced line becomes 0x1FF in narrow and wide modes, or 0 in legacy mode.
- R11: slot_clks is 20 in narrow and legacy modes. In wide mode it is 16, except for slots 230 to 245, where even offsets from 230 give 19 and odd offsets give 18.
- R12: Mode inputs that change in the middle of a line have no effect until the line-change slot has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| new_mode_en | input | 1 | 1 selects narrow or wide mode, 0 selects legacy mode |
| wide_en | input | 1 | With new_mode_en set, 1 selects wide mode |
| bg_index | input | 6 | Background-colour palette index |
| inactive_start | input | 9 | First inactive line |
| border_bottom | input | 8 | Bottom border height in lines |
| border_top | input | 8 | Top border height in lines |
| slot | output | 8 | Current horizontal slot |
| vline | output | 9 | Vertical line counter |
| buf_clear | output | 1 | Sprite line-buffer clear strobe |
| idx_reset | output | 1 | Sprite index reset strobe |
| idx_load | output | 8 | Value loaded on an index reset |
| vint_set | output | 1 | Vertical-interrupt pending strobe |
| line_adv | output | 1 | Line-change strobe |
| seq_done | output | 1 | Inactive sequence finishes at this line change |
| pix_we | output | 1 | Border pixel-pair write enable |
| pix_idx | output | 9 | Index of the first pixel of the pair |
| pix_color | output | 7 | Palette address for the pair |
| slot_clks | output | 5 | Master clocks in the current slot |

## Verification
The sequence runs in each of the three modes, and every cycle is checked against a model, so that any slot where a mode's jump points or event slots are swapped shows up. Inactive-start and border heights are chosen so that some lines fall inside the border and others do not, and so that the vertical counter wraps from 0x1FF to 0. This separates the bottom-border and top-border comparisons, and it separates the per-mode interrupt line and end line. A final run switches the mode halfway through a line. It shows that the jump point and the event slots follow the latched mode and not the live input.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

    typedef enum logic [1:0] {
        VM_NARROW = 2'd0,
        VM_WIDE   = 2'd1,
        VM_LEGACY = 2'd2
    } vmode_e;

    localparam int SLOT_W = 8;
    localparam int LINE_W = 9;
    localparam int CLKW   = 5;

    localparam logic [SLOT_W-1:0] BG_FIRST   = 8'd9;
    localparam logic [LINE_W-1:0] END_NEW    = 9'h1FF;
    localparam logic [LINE_W-1:0] END_LEGACY = 9'h000;
    localparam logic [2:0]        LEG_PAL_HI = 3'b101;
    localparam logic [CLKW-1:0]   CLKS_WIDE  = 5'd16;
    localparam logic [CLKW-1:0]   CLKS_SLOW  = 5'd20;

    typedef struct packed {
        logic [SLOT_W-1:0] jump_from;
        logic [SLOT_W-1:0] jump_to;
        logic [SLOT_W-1:0] clr_slot;
        logic [SLOT_W-1:0] idx_slot;
        logic [SLOT_W-1:0] idx_val;
        logic [SLOT_W-1:0] bg_end;
    } mode_cfg_t;

    typedef struct packed {
        logic buf_clear;
        logic idx_reset;
        logic vint_set;
        logic line_adv;
    } evt_t;

    function automatic vmode_e decode_mode(input logic new_en, input logic wide);
        if (!new_en)   return VM_LEGACY;
        else if (wide) return VM_WIDE;
        else           return VM_NARROW;
    endfunction

    function automatic mode_cfg_t cfg_of(input vmode_e m);
        mode_cfg_t c;
        case (m)
            VM_WIDE: begin
                c.jump_from = 8'd182; c.jump_to = 8'd229;
                c.clr_slot  = 8'd161; c.idx_slot = 8'd165;
                c.idx_val   = 8'h80;  c.bg_end   = BG_FIRST + 8'd160;
            end
            VM_NARROW: begin
                c.jump_from = 8'd147; c.jump_to = 8'd233;
                c.clr_slot  = 8'd128; c.idx_slot = 8'd132;
                c.idx_val   = 8'h80;  c.bg_end   = BG_FIRST + 8'd128;
            end
            default: begin
                c.jump_from = 8'd147; c.jump_to = 8'd233;
                c.clr_slot  = 8'd136; c.idx_slot = 8'd253;
                c.idx_val   = 8'h00;  c.bg_end   = BG_FIRST + 8'd128;
            end
        endcase
        return c;
    endfunction

    // Per-slot duration inside the wide-mode sync window
    function automatic logic [CLKW-1:0] sync_clks(input logic [SLOT_W-1:0] off);
        return off[0] ? 5'd18 : 5'd19;
    endfunction

endpackage

// File: rtl/vsq_slot_ctr.sv
module vsq_slot_ctr
    import vsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  vmode_e            mode_in,
    input  logic              line_adv,
    output logic [SLOT_W-1:0] slot,
    output vmode_e            mode_q
);
    mode_cfg_t         cfg;
    logic [SLOT_W-1:0] slot_nx;

    always_comb begin
        cfg = cfg_of(mode_q);
        if (slot == cfg.jump_from) slot_nx = cfg.jump_to;
        else                       slot_nx = slot + 8'd1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '0;
            mode_q <= mode_in;
        end else begin
            slot <= slot_nx;
            if (line_adv) mode_q <= mode_in;
        end
    end
endmodule

// File: rtl/vsq_line_ctr.sv
module vsq_line_ctr
    import vsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] inactive_start,
    input  logic              line_adv,
    input  vmode_e            mode_q,
    output logic [LINE_W-1:0] vline,
    output logic              seq_done
);
    logic [LINE_W-1:0] vline_nx;
    logic [LINE_W-1:0] end_line;

    always_comb begin
        vline_nx = vline + 9'd1;
        end_line = (mode_q == VM_LEGACY) ? END_LEGACY : END_NEW;
        seq_done = line_adv && (vline_nx == end_line);
    end

    always_ff @(posedge clk) begin
        if (rst)           vline <= inactive_start;
        else if (line_adv) vline <= vline_nx;
    end
endmodule

// File: rtl/vsq_event_dec.sv
module vsq_event_dec
    import vsq_pkg::*;
#(
    parameter logic [7:0] LCHG_WIDE   = 8'd166,
    parameter logic [7:0] LCHG_NARROW = 8'd133,
    parameter logic [7:0] LCHG_LEG    = 8'd134,
    parameter logic [7:0] VINT_WIDE   = 8'd2,
    parameter logic [7:0] VINT_NARROW = 8'd1,
    parameter logic [7:0] VINT_LEG    = 8'd3,
    parameter int         HS_BEGIN    = 230,
    parameter int         HS_LEN      = 16
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [LINE_W-1:0] vline,
    input  logic [LINE_W-1:0] inactive_start,
    input  vmode_e            mode_q,
    output evt_t              evt,
    output logic [SLOT_W-1:0] idx_load,
    output logic [CLKW-1:0]   slot_clks
);
    localparam int HS_END = HS_BEGIN + HS_LEN;

    mode_cfg_t         cfg;
    logic [SLOT_W-1:0] lchg_slot;
    logic [SLOT_W-1:0] vint_slot;
    logic [LINE_W-1:0] vint_line;
    logic [SLOT_W-1:0] hs_off;
    logic              in_sync;

    always_comb begin
        cfg = cfg_of(mode_q);
        case (mode_q)
            VM_WIDE: begin
                lchg_slot = LCHG_WIDE;
                vint_slot = VINT_WIDE;
            end
            VM_NARROW: begin
                lchg_slot = LCHG_NARROW;
                vint_slot = VINT_NARROW;
            end
            default: begin
                lchg_slot = LCHG_LEG;
                vint_slot = VINT_LEG;
            end
        endcase
        vint_line = (mode_q == VM_LEGACY) ? inactive_start + 9'd1 : inactive_start;

        evt.buf_clear = (slot == cfg.clr_slot);
        evt.idx_reset = (slot == cfg.idx_slot);
        evt.vint_set  = (slot == vint_slot) && (vline == vint_line);
        evt.line_adv  = (slot == lchg_slot);
        idx_load      = cfg.idx_val;

        in_sync = (int'(slot) >= HS_BEGIN) && (int'(slot) < HS_END);
        hs_off  = slot - SLOT_W'(HS_BEGIN);
        if (mode_q != VM_WIDE) slot_clks = CLKS_SLOW;
        else if (in_sync)      slot_clks = sync_clks(hs_off);
        else                   slot_clks = CLKS_WIDE;
    end
endmodule

// File: rtl/vsq_border_gen.sv
module vsq_border_gen
    import vsq_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [LINE_W-1:0] vline,
    input  logic [LINE_W-1:0] inactive_start,
    input  logic [7:0]        border_bottom,
    input  logic [7:0]        border_top,
    input  logic [5:0]        bg_index,
    input  vmode_e            mode_q,
    output logic              pix_we,
    output logic [LINE_W-1:0] pix_idx,
    output logic [6:0]        pix_color
);
    mode_cfg_t   cfg;
    logic [9:0]  lo_lim;
    logic [9:0]  hi_lim;
    logic        v_border;
    logic        h_win;
    logic [SLOT_W-1:0] rel;

    always_comb begin
        cfg      = cfg_of(mode_q);
        lo_lim   = {1'b0, inactive_start} + {2'b00, border_bottom};
        hi_lim   = 10'h200 - {2'b00, border_top};
        v_border = ({1'b0, vline} < lo_lim) || ({1'b0, vline} > hi_lim);
        h_win    = (slot >= BG_FIRST) && (slot < cfg.bg_end);
        rel      = slot - BG_FIRST;
        pix_we   = v_border && h_win;
        pix_idx  = h_win ? {rel, 1'b0} : '0;
        if (mode_q == VM_LEGACY) pix_color = {LEG_PAL_HI, bg_index[3:0]};
        else                     pix_color = {1'b0, bg_index};
    end
endmodule

// File: rtl/vblank_slot_seq.sv
module vblank_slot_seq
    import vsq_pkg::*;
#(
    parameter logic [7:0] LCHG_WIDE   = 8'd166,
    parameter logic [7:0] LCHG_NARROW = 8'd133,
    parameter logic [7:0] LCHG_LEG    = 8'd134,
    parameter logic [7:0] VINT_WIDE   = 8'd2,
    parameter logic [7:0] VINT_NARROW = 8'd1,
    parameter logic [7:0] VINT_LEG    = 8'd3,
    parameter int         HS_BEGIN    = 230,
    parameter int         HS_LEN      = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       new_mode_en,
    input  logic       wide_en,
    input  logic [5:0] bg_index,
    input  logic [8:0] inactive_start,
    input  logic [7:0] border_bottom,
    input  logic [7:0] border_top,
    output logic [7:0] slot,
    output logic [8:0] vline,
    output logic       buf_clear,
    output logic       idx_reset,
    output logic [7:0] idx_load,
    output logic       vint_set,
    output logic       line_adv,
    output logic       seq_done,
    output logic       pix_we,
    output logic [8:0] pix_idx,
    output logic [6:0] pix_color,
    output logic [4:0] slot_clks
);
    vmode_e mode_in;
    vmode_e mode_q;
    evt_t   evt;

    assign mode_in = decode_mode(new_mode_en, wide_en);

    vsq_slot_ctr u_slot (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_in),
        .line_adv (evt.line_adv),
        .slot     (slot),
        .mode_q   (mode_q)
    );

    vsq_line_ctr u_line (
        .clk            (clk),
        .rst            (rst),
        .inactive_start (inactive_start),
        .line_adv       (evt.line_adv),
        .mode_q         (mode_q),
        .vline          (vline),
        .seq_done       (seq_done)
    );

    vsq_event_dec #(
        .LCHG_WIDE   (LCHG_WIDE),
        .LCHG_NARROW (LCHG_NARROW),
        .LCHG_LEG    (LCHG_LEG),
        .VINT_WIDE   (VINT_WIDE),
        .VINT_NARROW (VINT_NARROW),
        .VINT_LEG    (VINT_LEG),
        .HS_BEGIN    (HS_BEGIN),
        .HS_LEN      (HS_LEN)
    ) u_evt (
        .slot           (slot),
        .vline          (vline),
        .inactive_start (inactive_start),
        .mode_q         (mode_q),
        .evt            (evt),
        .idx_load       (idx_load),
        .slot_clks      (slot_clks)
    );

    vsq_border_gen u_bdr (
        .slot           (slot),
        .vline          (vline),
        .inactive_start (inactive_start),
        .border_bottom  (border_bottom),
        .border_top     (border_top),
        .bg_index       (bg_index),
        .mode_q         (mode_q),
        .pix_we         (pix_we),
        .pix_idx        (pix_idx),
        .pix_color      (pix_color)
    );

    assign buf_clear = evt.buf_clear;
    assign idx_reset = evt.idx_reset;
    assign vint_set  = evt.vint_set;
    assign line_adv  = evt.line_adv;
endmodule

// File: rtl/vblank_slot_seq_chk.sv
module vblank_slot_seq_chk
    import vsq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_q,
    input logic [7:0] slot,
    input logic [8:0] vline,
    input logic [8:0] inactive_start,
    input logic       buf_clear,
    input logic       idx_reset,
    input logic       vint_set,
    input logic       line_adv,
    input logic       seq_done,
    input logic       pix_we,
    input logic [8:0] pix_idx
);
    logic wide_m;
    assign wide_m = (mode_q == VM_WIDE);

    a_r2_wide_jump: assert property (@(posedge clk) disable iff (rst)
        (wide_m && slot == 8'd182) |=> (slot == 8'd229));

    a_r2_narrow_jump: assert property (@(posedge clk) disable iff (rst)
        (!wide_m && slot == 8'd147) |=> (slot == 8'd233));

    a_r2_plain_step: assert property (@(posedge clk) disable iff (rst)
        (!(wide_m && slot == 8'd182) && !(!wide_m && slot == 8'd147))
        |=> (slot == $past(slot) + 8'd1));

    a_r3_strobes_apart: assert property (@(posedge clk) disable iff (rst)
        $onehot0({buf_clear, idx_reset}));

    a_r5_pix_bound: assert property (@(posedge clk) disable iff (rst)
        pix_we |-> (pix_idx < 9'd320 && pix_idx[0] == 1'b0));

    a_r8_vint_line: assert property (@(posedge clk) disable iff (rst)
        vint_set |-> (vline == inactive_start || vline == inactive_start + 9'd1));

    a_r9_line_step: assert property (@(posedge clk) disable iff (rst)
        line_adv |=> (vline == $past(vline) + 9'd1));

    a_r9_line_hold: assert property (@(posedge clk) disable iff (rst)
        !line_adv |=> $stable(vline));

    a_r10_done_at_adv: assert property (@(posedge clk) disable iff (rst)
        seq_done |-> line_adv);

    a_r12_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !line_adv |=> $stable(mode_q));
endmodule

bind vblank_slot_seq vblank_slot_seq_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode_q         (mode_q),
    .slot           (slot),
    .vline          (vline),
    .inactive_start (inactive_start),
    .buf_clear      (buf_clear),
    .idx_reset      (idx_reset),
    .vint_set       (vint_set),
    .line_adv       (line_adv),
    .seq_done       (seq_done),
    .pix_we         (pix_we),
    .pix_idx        (pix_idx)
);

// File: tb/vblank_slot_seq_tb.sv
module vblank_slot_seq_tb;
    localparam int CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       new_mode_en = 1'b1;
    logic       wide_en = 1'b1;
    logic [5:0] bg_index = '0;
    logic [8:0] inactive_start = '0;
    logic [7:0] border_bottom = '0;
    logic [7:0] border_top = '0;
    logic [7:0] slot;
    logic [8:0] vline;
    logic       buf_clear, idx_reset, vint_set, line_adv, seq_done, pix_we;
    logic [7:0] idx_load;
    logic [8:0] pix_idx;
    logic [6:0] pix_color;
    logic [4:0] slot_clks;

    vblank_slot_seq u_dut (
        .clk(clk), .rst(rst), .new_mode_en(new_mode_en), .wide_en(wide_en),
        .bg_index(bg_index), .inactive_start(inactive_start),
        .border_bottom(border_bottom), .border_top(border_top),
        .slot(slot), .vline(vline), .buf_clear(buf_clear), .idx_reset(idx_reset),
        .idx_load(idx_load), .vint_set(vint_set), .line_adv(line_adv),
        .seq_done(seq_done), .pix_we(pix_we), .pix_idx(pix_idx),
        .pix_color(pix_color), .slot_clks(slot_clks)
    );

    always #(CLK_PER/2) clk = ~clk;

    typedef struct {
        int slot; int vline; bit bc; bit ir; int iv; bit vi; bit la; bit sd;
        bit we; int pidx; int col; int clks;
    } exp_t;

    exp_t  q[$];
    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 0;
    string phase = "init";

    // Reference state, built from the requirements
    int m_slot, m_line, m_mode;   // mode: 0 narrow, 1 wide, 2 legacy

    function automatic int mode_from(bit n, bit w);
        if (!n) return 2;
        return w ? 1 : 0;
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] actual=%0d expected=%0d at t=%0t", tag, phase, act, expv, $time);
        end
    endtask

    function automatic exp_t predict();
        exp_t e;
        int jf, clr, ixs, ixv, bend, lchg, vs, vl, endl;
        bit vb;
        if (m_mode == 1) begin
            clr = 161; ixs = 165; ixv = 128; bend = 169; lchg = 166; vs = 2;
        end else if (m_mode == 0) begin
            clr = 128; ixs = 132; ixv = 128; bend = 137; lchg = 133; vs = 1;
        end else begin
            clr = 136; ixs = 253; ixv = 0;   bend = 137; lchg = 134; vs = 3;
        end
        jf = 0;
        vl   = (m_mode == 2) ? (int'(inactive_start) + 1) % 512 : int'(inactive_start);
        endl = (m_mode == 2) ? 0 : 511;
        vb = (m_line < int'(inactive_start) + int'(border_bottom)) ||
             (m_line > 512 - int'(border_top));
        e.slot = m_slot; e.vline = m_line;
        e.bc = (m_slot == clr);
        e.ir = (m_slot == ixs);
        e.iv = ixv;
        e.vi = (m_slot == vs) && (m_line == vl);
        e.la = (m_slot == lchg);
        e.sd = e.la && (((m_line + 1) % 512) == endl);
        e.we = vb && (m_slot >= 9) && (m_slot < bend);
        e.pidx = 2 * (m_slot - 9);
        e.col = (m_mode == 2) ? (80 + int'(bg_index[3:0])) : int'(bg_index);
        if (m_mode != 1) e.clks = 20;
        else if (m_slot >= 230 && m_slot < 246) e.clks = ((m_slot - 230) % 2 == 0) ? 19 : 18;
        else e.clks = 16;
        return e;
    endfunction

    task automatic advance();
        int lchg;
        lchg = (m_mode == 1) ? 166 : (m_mode == 0) ? 133 : 134;
        if (m_slot == lchg) begin
            m_line = (m_line + 1) % 512;
            m_mode = mode_from(new_mode_en, wide_en);
        end
        if (m_mode_jump()) m_slot = (m_slot_is_wide_prev) ? 229 : 233;
        else m_slot = (m_slot + 1) % 256;
    endtask

    // jump decision uses the mode that was in force for the slot just predicted
    bit m_slot_is_wide_prev;
    function automatic bit m_mode_jump();
        return (m_slot_is_wide_prev && m_slot == 182) || (!m_slot_is_wide_prev && m_slot == 147);
    endfunction

    // Driver: pushes the expected item for the current slot, then steps the model
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            q.push_back(predict());
            m_slot_is_wide_prev = (m_mode == 1);
            advance();
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_slot = 0;
        m_line = int'(inactive_start);
        m_mode = mode_from(new_mode_en, wide_en);
        #2;
        // R1: reset state at the ports
        check(slot == 8'd0, "R1 slot", slot, 0);
        check(vline == inactive_start, "R1 vline", vline, inactive_start);
        check({buf_clear, idx_reset, vint_set, line_adv, seq_done, pix_we} == 6'b0,
              "R1 strobes", {buf_clear, idx_reset, vint_set, line_adv, seq_done, pix_we}, 0);
    endtask

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(int'(slot) == e.slot, "R2 slot", slot, e.slot);
                check(int'(vline) == e.vline, "R9 vline", vline, e.vline);
                check(buf_clear == e.bc, "R3 buf_clear", buf_clear, e.bc);
                check(idx_reset == e.ir, "R4 idx_reset", idx_reset, e.ir);
                if (e.ir) check(int'(idx_load) == e.iv, "R4 idx_load", idx_load, e.iv);
                check(vint_set == e.vi, "R8 vint_set", vint_set, e.vi);
                check(line_adv == e.la, "R9 line_adv", line_adv, e.la);
                check(seq_done == e.sd, "R10 seq_done", seq_done, e.sd);
                check(pix_we == e.we, "R5 R6 pix_we", pix_we, e.we);
                if (e.we) begin
                    check(int'(pix_idx) == e.pidx, "R5 pix_idx", pix_idx, e.pidx);
                    check(int'(pix_color) == e.col, "R7 pix_color", pix_color, e.col);
                end
                check(int'(slot_clks) == e.clks, "R11 slot_clks", slot_clks, e.clks);
            end
        end
    end

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Wide mode: lines 0x1FC,0x1FD are bottom border, wrap to 0 afterwards
        phase = "wide";
        new_mode_en = 1; wide_en = 1; bg_index = 6'h2A;
        inactive_start = 9'h1FC; border_bottom = 8'd2; border_top = 8'd1;
        do_reset();
        @(negedge clk);
        m_slot_is_wide_prev = 1;
        q.delete();
        // realign model to the current slot after the R1 sampling cycle
        m_slot = 1;
        step(1000);

        phase = "narrow";
        new_mode_en = 1; wide_en = 0; bg_index = 6'h15;
        inactive_start = 9'h1FC; border_bottom = 8'd0; border_top = 8'd3;
        do_reset();
        @(negedge clk);
        m_slot = 1;
        step(800);

        phase = "legacy";
        new_mode_en = 0; wide_en = 1; bg_index = 6'h3B;
        inactive_start = 9'h1FE; border_bottom = 8'd1; border_top = 8'd0;
        do_reset();
        @(negedge clk);
        m_slot = 1;
        step(800);

        // R12: switch from wide to narrow halfway through a line
        phase = "R12 mode latch";
        new_mode_en = 1; wide_en = 1; bg_index = 6'h07;
        inactive_start = 9'h1F0; border_bottom = 8'd4; border_top = 8'd2;
        do_reset();
        @(negedge clk);
        m_slot = 1;
        step(100);
        wide_en = 0;
        step(500);
        new_mode_en = 0;
        step(300);

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule